// File: doc/BRIEF.md
# Gated Fractional Reference Clock Bank

This block holds one 32-bit control word that configures four reference clock channels. Each channel turns a fast source clock into a stream of single-cycle enable pulses. Over time, the pulse rate is 18/F of the source rate, where F is the channel's six-bit divisor field. Downstream logic that runs on the source clock uses each pulse as a clock enable, which gives it a slower reference rate without creating a new clock.

Software changes the word through a small write port. One address replaces the whole word. A second address turns on only the bits that are 1 in the written data. A third address turns off only the bits that are 1 in the written data. Because of the set and clear addresses, one channel can be started or stopped without a read-modify-write that could disturb the other channels. The whole word can always be read back.

Each channel has a gate bit. While the gate bit is 1, the channel's pulses stop and its phase accumulator is held at zero. When the gate bit is cleared, the pulse pattern therefore starts again from the same point every time.

Top module: `refclk_bank`

## Requirements
- R1: After reset, the word reads 0x92929292. In each byte this means gate = 1 and divisor = 18. All refEn outputs are 0.
- R2: A write to busAddr 0 replaces the whole word. busRdData always returns all 32 bits, including bit 8n+6 of each byte.
- R3: A write to busAddr 1 ORs busWrData into the word.
- R4: A write to busAddr 2 clears every word bit that is 1 in busWrData.
- R5: A write to busAddr 3 leaves the word unchanged.
- R6: Channel n's divisor F is bits 8n+5..8n, and its gate is bit 8n+7. While the gate is 1, refEn[n] stays 0.
- R7: Let a write at clock edge k leave channel n with gate 0 after a gated state. Then at edge k+j (for j ≥ 1), refEn[n] is 1 exactly when floor(18j/F) > floor(18(j-1)/F). This gives exactly 18 pulses in every F cycles.
- R8: When F = 18, refEn[n] is 1 on every cycle while the channel is ungated.
- R9: A divisor below 18 behaves as 18, and a divisor above 35 behaves as 35. While a channel stays ungated, its output is never 0 on two cycles in a row.
- R10: Bit 8n+6 has no effect on any output.
- R11: Gating a channel and then releasing it restarts its pattern at j = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busAddr | input | 2 | 0 = replace word, 1 = set bits, 2 = clear bits, 3 = no effect |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Current control word |
| refEn | output | 4 | Enable pulse, one bit per channel |

## Verification
Some properties are checked by assertions on every clock cycle:
- A gated channel produces no pulse on the following cycle.
- The accumulator stays below the effective divisor.
- A channel with divisor 18 pulses every cycle.
- An ungated channel never goes two cycles without a pulse.
- After a set write, the written bits are present in the word. After a clear write, they are absent.
- No more than one write strobe is active at a time.

The bench's scenarios cover what those checks cannot. It compares the exact pulse position on each cycle against the floor formula, for all 64 divisor codes. It confirms that the reserved bits have no effect. It checks that the pattern restarts after a gate cycle. It checks the readback value after each write type, including the write to the unused address.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  typedef struct packed {
    logic wrDirect;
    logic wrSet;
    logic wrClr;
  } ctrlStrobe_t;
endpackage

// File: rtl/refclk_ctrl.sv
module refclk_ctrl
  import refclk_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int ADDR_DIRECT = 0,
  parameter int ADDR_SET    = 1,
  parameter int ADDR_CLR    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobe_t       strobe
);
  always_comb begin
    strobe.wrDirect = wrEn && (addr == ADDR_W'(ADDR_DIRECT));
    strobe.wrSet    = wrEn && (addr == ADDR_W'(ADDR_SET));
    strobe.wrClr    = wrEn && (addr == ADDR_W'(ADDR_CLR));
  end

  // R2 R3 R4: at most one kind of update per cycle
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrDirect, strobe.wrSet, strobe.wrClr}));
endmodule

// File: rtl/refclk_chan.sv
module refclk_chan #(
  parameter int FRAC_W   = 6,
  parameter int NUMER    = 18,
  parameter int FRAC_MAX = 35,
  localparam int ACC_W   = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gate,
  input  logic [FRAC_W-1:0] fracIn,
  output logic              pulse
);
  logic [ACC_W-1:0] fracEff;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic             hit;

  always_comb begin
    if (fracIn < FRAC_W'(NUMER))          fracEff = ACC_W'(NUMER);
    else if (fracIn > FRAC_W'(FRAC_MAX))  fracEff = ACC_W'(FRAC_MAX);
    else                                  fracEff = {1'b0, fracIn};
    sum = acc + ACC_W'(NUMER);
    hit = (sum >= fracEff);
  end

  always_ff @(posedge clk) begin
    if (!rstN || gate) begin
      acc   <= '0;
      pulse <= 1'b0;
    end else begin
      acc   <= hit ? (sum - fracEff) : sum;
      pulse <= hit;
    end
  end

  // R6: gated channel emits nothing next cycle
  p_gate_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    gate |=> !pulse);
  // R7: residue stays below the effective divisor
  p_acc_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    acc < fracEff);
  // R8: divisor 18 means full rate
  p_full_rate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!gate && fracEff == ACC_W'(NUMER)) |=> pulse);
  // R9: clamped rate is above one half, so no two idle cycles in a row
  p_no_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!gate && $past(!gate) && !pulse) |=> pulse);
endmodule

// File: rtl/refclk_datapath.sv
module refclk_datapath
  import refclk_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int BYTE_W   = 8,
  parameter int FRAC_W   = 6,
  parameter int NUMER    = 18,
  parameter int FRAC_MAX = 35,
  localparam int WORD_W  = NUM_CHAN * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] word,
  output logic [NUM_CHAN-1:0] chanPulse
);
  localparam int RSV_W = BYTE_W - FRAC_W - 1;
  localparam logic [BYTE_W-1:0] BYTE_RST = {1'b1, {RSV_W{1'b0}}, FRAC_W'(NUMER)};
  localparam logic [WORD_W-1:0] WORD_RST = {NUM_CHAN{BYTE_RST}};

  always_ff @(posedge clk) begin
    if (!rstN)                word <= WORD_RST;
    else if (strobe.wrDirect) word <= wrData;
    else if (strobe.wrSet)    word <= word | wrData;
    else if (strobe.wrClr)    word <= word & ~wrData;
  end

  for (genvar n = 0; n < NUM_CHAN; n++) begin : g_chan
    refclk_chan #(
      .FRAC_W  (FRAC_W),
      .NUMER   (NUMER),
      .FRAC_MAX(FRAC_MAX)
    ) chan_i (
      .clk   (clk),
      .rstN  (rstN),
      .gate  (word[n*BYTE_W + BYTE_W - 1]),
      .fracIn(word[n*BYTE_W +: FRAC_W]),
      .pulse (chanPulse[n])
    );
  end

  // R3: set alias leaves all written ones present
  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSet |=> ((word & $past(wrData)) == $past(wrData)));
  // R4: clear alias leaves all written ones absent
  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrClr |=> ((word & $past(wrData)) == '0));
  // R5: no strobe, no change
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrDirect || strobe.wrSet || strobe.wrClr) |=> $stable(word));
endmodule

// File: rtl/refclk_bank.sv
module refclk_bank
  import refclk_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int BYTE_W   = 8,
  parameter int FRAC_W   = 6,
  parameter int NUMER    = 18,
  parameter int FRAC_MAX = 35,
  parameter int ADDR_W   = 2,
  localparam int WORD_W  = NUM_CHAN * BYTE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWrData,
  output logic [WORD_W-1:0]   busRdData,
  output logic [NUM_CHAN-1:0] refEn
);
  ctrlStrobe_t strobe;

  refclk_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (busWrEn),
    .addr  (busAddr),
    .strobe(strobe)
  );

  refclk_datapath #(
    .NUM_CHAN(NUM_CHAN),
    .BYTE_W  (BYTE_W),
    .FRAC_W  (FRAC_W),
    .NUMER   (NUMER),
    .FRAC_MAX(FRAC_MAX)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWrData),
    .word     (busRdData),
    .chanPulse(refEn)
  );
endmodule

// File: tb/refclk_bank_tb_top.sv
module refclk_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  refEn;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  refclk_bank dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .refEn(refEn)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  function automatic int effDiv(input int f);
    if (f < 18) return 18;
    if (f > 35) return 35;
    return f;
  endfunction

  function automatic bit expPulse(input int j, input int f);
    return ((18 * j) / f) != ((18 * (j - 1)) / f);
  endfunction

  // R7 R11: observe pattern from j=1 for channels in mask, word w just written
  task automatic checkPattern(input logic [31:0] w, input logic [3:0] mask, input int ncyc, input string req);
    int bad [4];
    int cnt [4];
    int div [4];
    for (int n = 0; n < 4; n++) begin
      bad[n] = 0; cnt[n] = 0;
      div[n] = effDiv(int'(w[n*8 +: 6]));
    end
    for (int j = 1; j <= ncyc; j++) begin
      @(posedge clk);
      @(negedge clk);
      for (int n = 0; n < 4; n++) begin
        if (refEn[n] != expPulse(j, div[n])) bad[n]++;
        if (j <= div[n] && refEn[n]) cnt[n]++;
      end
    end
    for (int n = 0; n < 4; n++) begin
      if (mask[n]) begin
        check(bad[n] == 0, req, 32'(bad[n]), 32'd0);
        if (ncyc >= div[n]) check(cnt[n] == 18, {req, " R7 count"}, 32'(cnt[n]), 32'd18);
      end
    end
  endtask

  task automatic gateAll();
    busWrite(2'd1, 32'h80808080);
  endtask

  initial begin
    logic [31:0] prev;
    int quiet;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busRdData == 32'h92929292, "R1 word", busRdData, 32'h92929292);
    quiet = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (refEn != 4'h0) quiet++;
    end
    check(quiet == 0, "R1 R6 outputs idle", 32'(quiet), 32'd0);

    // R2 R7 R8: direct write, divisors 18/35/27/20, reserved bit set on ch2
    busWrite(2'd0, 32'h141B2312 | 32'h00400000);
    check(busRdData == 32'h145B2312, "R2 readback", busRdData, 32'h145B2312);
    checkPattern(32'h145B2312, 4'hF, 72, "R7 R8 R10 pattern");

    // R3 R6: set gates of ch1 and ch3
    prev = busRdData;
    busWrite(2'd1, 32'h80008000);
    check(busRdData == (prev | 32'h80008000), "R3 set alias", busRdData, prev | 32'h80008000);
    quiet = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (refEn[1] || refEn[3]) quiet++;
    end
    check(quiet == 0, "R6 gated quiet", 32'(quiet), 32'd0);

    // R4 R11: clear gates, ch1 and ch3 restart at j=1
    prev = busRdData;
    busWrite(2'd2, 32'h80008000);
    check(busRdData == (prev & ~32'h80008000), "R4 clr alias", busRdData, prev & ~32'h80008000);
    checkPattern(busRdData, 4'hA, 72, "R11 restart");

    // R5: write to unused address
    prev = busRdData;
    busWrite(2'd3, 32'h00000000);
    check(busRdData == prev, "R5 unused addr", busRdData, prev);
    busWrite(2'd3, 32'hFFFFFFFF);
    check(busRdData == prev, "R5 unused addr ones", busRdData, prev);

    // R9 R10: clamp and reserved-bit cases on distinct channels
    gateAll();
    busWrite(2'd0, 32'h64115F00);
    checkPattern(32'h64115F00, 4'hF, 72, "R9 R10 clamp");

    // R7 R9: sweep of every divisor code on all channels
    for (int f = 0; f < 64; f++) begin
      gateAll();
      busWrite(2'd0, {4{2'b00, 6'(f)}});
      checkPattern({4{2'b00, 6'(f)}}, 4'hF, 36, "R7 R9 sweep");
    end

    // R6: gate everything again
    gateAll();
    @(negedge clk);
    check(refEn == 4'h0, "R6 all gated", 32'(refEn), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule